// File: doc/BRIEF.md
# T1/E1 Frame Elastic Store

This block takes a bit-serial T1 or E1 stream written at the line bit rate and hands it out at the system bit rate. It holds up to two frames. When the two rates differ, the distance between writer and reader drifts. The store absorbs that drift until the distance gets too small or too large. At that point it performs a controlled slip of exactly one frame at the start of a read frame, then records the slip and which way it went. Both bit clocks reach the block as single-cycle enables in one fast clock domain: `wr_en` for the line bit clock and `rd_en` for the system bit clock. A system clock of 1.544 MHz or 2.048 MHz only changes how often `rd_en` is asserted.

Two initialization commands move the read pointer by whole frames so that the write-to-read delay falls into a known window. The reset command's window depends on which direction the store serves. The align command always uses a window centred on one frame. A minimum delay mode replaces the two-frame ring with a 32-bit ring at a fixed lag and disables the slip logic. It is intended for a system clock that is locked to the line clock. The frame sync inputs may pulse every frame or once per multiframe, because the frame position counters run freely between pulses.

Latency below means the number of `rd_en` strobes from the strobe that writes a bit to the strobe that presents that bit on `rd_data`, with both enables asserted together. `rd_data` is registered and changes only in the cycle after an `rd_en`.

Top module: `es_frame_store`

## Requirements
- R1: The frame length is 193 bits when `e1_mode` is 0 and 256 bits when it is 1. After reset, with both enables asserted in every cycle, the latency settles at exactly one frame.
- R2: Reset clears `slip_flag`, `slip_dir` and `rd_data` to 0. `rd_data` holds its value in every cycle that follows a cycle without `rd_en`.
- R3: At the start of a read frame, if the delay is below a quarter frame, the store reads the previous frame again (repeat). It sets `slip_flag` and sets `slip_dir` to 2'b01. The read pointer's first frame after reset always takes this repeat.
- R4: At the start of a read frame, if the delay exceeds seven quarters of a frame, the store skips one frame (delete). It sets `slip_flag` and sets `slip_dir` to 2'b10.
- R5: `slip_flag` stays set until `slip_clr` is asserted, and a clear wins over a slip in the same cycle. `slip_dir` keeps the code of the most recent slip and is not changed by a clear.
- R6: On a rising edge of `cmd_reset`, the read pointer moves so that the latency lies in [F, 2F) when `tx_dir` is 1 and in [0, F) when `tx_dir` is 0, where F is the frame length.
- R7: Only the 0-to-1 transition of `cmd_reset` acts. Holding it high leaves later drift in the latency uncorrected.
- R8: On a rising edge of `cmd_align`, the read pointer moves so that the latency lies in [F/2, 3F/2).
- R9: While `min_delay` is 1, the store is a 32-bit ring. Entering the mode, or a `cmd_reset` edge within it, sets the latency to exactly 16. No slip is taken and `slip_flag` and `slip_dir` do not change, even when the rates differ.
- R10: An `rd_sync` pulse together with `rd_en` in mid-frame starts a new read frame at bit 0 of the other frame half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast common clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e1_mode | input | 1 | 1: 256-bit frames, 0: 193-bit frames |
| min_delay | input | 1 | Selects the 32-bit fixed-lag ring |
| tx_dir | input | 1 | 1: transmit-direction reset window, 0: receive-direction window |
| wr_en | input | 1 | Line bit strobe |
| wr_sync | input | 1 | With wr_en, marks bit 0 of a line frame |
| wr_data | input | 1 | Line data bit |
| rd_en | input | 1 | System bit strobe |
| rd_sync | input | 1 | With rd_en, marks bit 0 of a system frame or multiframe |
| rd_data | output | 1 | System data bit, registered |
| cmd_reset | input | 1 | Reset initialization, acts on its rising edge |
| cmd_align | input | 1 | Align initialization, acts on its rising edge |
| slip_clr | input | 1 | Clears slip_flag |
| slip_flag | output | 1 | Sticky slip indication |
| slip_dir | output | 2 | Last slip: bit 0 repeat, bit 1 delete |

## Verification
The bench measures latency directly. It places a single marked bit in an otherwise cleared stream and counts read strobes until the mark appears. This exposes a reset or align command that picks the wrong frame half: the latency would land outside its window. It also exposes a mid-frame read sync that restarts in the wrong half, which would be off by a whole frame. Rates are skewed in both directions, so a design with the two slip thresholds or direction codes swapped reports the wrong `slip_dir`. A held `cmd_reset` followed by drift catches a level-sensitive command, which would pull the latency back into its window. Minimum delay mode is run with mismatched rates, so a design that leaves slip logic active there raises the flag.

// File: rtl/es_frame_pkg.sv
// Shared constants for the frame elastic store.
package es_frame_pkg;
    localparam int unsigned T1_FRAME_BITS = 193;
    localparam int unsigned E1_FRAME_BITS = 256;

    // Bit positions of the slip direction code.
    localparam int unsigned DIR_REPEAT = 0;
    localparam int unsigned DIR_DELETE = 1;
endpackage

// File: rtl/es_bit_ram.sv
// Single-bit storage ring with one write port and one registered read port.
// Assumes the caller keeps addresses below DEPTH.
module es_bit_ram #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    logic store [DEPTH];

    // Write the incoming bit.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Register the outgoing bit; hold it when no read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= 1'b0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/es_wr_ctrl.sv
// Write-side frame pointer: frame half plus bit position, flywheeling
// between sync pulses. A mid-frame sync starts bit 0 of the other half.
// Assumes flen does not exceed 2**FW-1.
module es_wr_ctrl #(
    parameter int AW = 9,
    parameter int FW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] flen,
    input  logic          wr_en,
    input  logic          wr_sync,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] wnext
);
    logic          half_q;
    logic [FW-1:0] pos_q;
    logic          start;
    logic          half_now;
    logic [FW-1:0] pos_now;

    // Resolve the address used by the current strobe.
    always_comb begin
        start    = wr_en && (pos_q == '0 || wr_sync);
        half_now = (wr_sync && pos_q != '0) ? ~half_q : half_q;
        pos_now  = start ? '0 : pos_q;
        waddr    = (half_now ? AW'(flen) : '0) + AW'(pos_now);
        wnext    = (half_q ? AW'(flen) : '0) + AW'(pos_q);
    end

    // Advance the pointer, wrapping into the other half at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            pos_q  <= '0;
        end else if (wr_en) begin
            if (pos_now >= flen - FW'(1)) begin
                pos_q  <= '0;
                half_q <= ~half_now;
            end else begin
                pos_q  <= pos_now + FW'(1);
                half_q <= half_now;
            end
        end
    end
endmodule

// File: rtl/es_rd_ctrl.sv
// Read-side frame pointer with slip decision and the two initializations.
// The slip check runs only at a read frame start and moves the read half by
// one frame. Assumes initialization edges do not coincide with rd_en.
module es_rd_ctrl #(
    parameter int AW = 9,
    parameter int FW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] flen,
    input  logic          rd_en,
    input  logic          rd_sync,
    input  logic [AW-1:0] wnext,
    input  logic          slip_en,
    input  logic          init_reset,
    input  logic          init_align,
    input  logic          tx_dir,
    output logic [AW-1:0] raddr,
    output logic          slip_rep,
    output logic          slip_del
);
    localparam int DW = AW + 3;

    logic          half_q;
    logic [FW-1:0] pos_q;
    logic [DW-1:0] f, two_f, d_start, d_now;
    logic          start, half_s, half_use, under, over, take_slip, keep;
    logic [FW-1:0] pos_now;

    // Distance from b forward to a around a ring of length twof.
    function automatic logic [DW-1:0] span(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic [DW-1:0] twof);
        return (a >= b) ? (a - b) : (a + twof - b);
    endfunction

    // Slip decision at a read frame start and the read address.
    always_comb begin
        f         = DW'(flen);
        two_f     = f << 1;
        start     = rd_en && (pos_q == '0 || rd_sync);
        half_s    = (rd_sync && pos_q != '0) ? ~half_q : half_q;
        d_start   = span(DW'(wnext), half_s ? f : '0, two_f);
        under     = slip_en && ((d_start << 2) < f);
        over      = slip_en && ((d_start << 2) > (f * DW'(7)));
        take_slip = start && (under || over);
        half_use  = take_slip ? ~half_s : half_s;
        pos_now   = start ? '0 : pos_q;
        raddr     = AW'((half_use ? f : '0) + DW'(pos_now));
        slip_rep  = take_slip && under;
        slip_del  = take_slip && over;
    end

    // Initialization: keep the current half when the delay already fits.
    always_comb begin
        d_now = span(DW'(wnext), (half_q ? f : '0) + DW'(pos_q), two_f);
        if (init_align)   keep = ((d_now << 1) >= f) && ((d_now << 1) < (f * DW'(3)));
        else if (tx_dir)  keep = (d_now >= f);
        else              keep = (d_now < f);
    end

    // Advance the read pointer or apply an initialization.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            pos_q  <= '0;
        end else if (init_reset || init_align) begin
            if (!keep) half_q <= ~half_q;
        end else if (rd_en) begin
            if (pos_now >= flen - FW'(1)) begin
                pos_q  <= '0;
                half_q <= ~half_use;
            end else begin
                pos_q  <= pos_now + FW'(1);
                half_q <= half_use;
            end
        end
    end
endmodule

// File: rtl/es_frame_store.sv
// Bit-serial T1/E1 elastic store between a line bit strobe and a system
// bit strobe in one fast clock. Two-frame ring with whole-frame slips, or a
// 32-bit fixed-lag ring in minimum delay mode. Commands act on rising edges
// and are expected in cycles without wr_en or rd_en.
module es_frame_store #(
    parameter int FRAME_MAX = 256,
    parameter int MIN_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e1_mode,
    input  logic       min_delay,
    input  logic       tx_dir,
    input  logic       wr_en,
    input  logic       wr_sync,
    input  logic       wr_data,
    input  logic       rd_en,
    input  logic       rd_sync,
    output logic       rd_data,
    input  logic       cmd_reset,
    input  logic       cmd_align,
    input  logic       slip_clr,
    output logic       slip_flag,
    output logic [1:0] slip_dir
);
    import es_frame_pkg::*;

    localparam int DEPTH   = 2 * FRAME_MAX;
    localparam int AW      = $clog2(DEPTH);
    localparam int FW      = $clog2(FRAME_MAX + 1);
    localparam int MW      = $clog2(MIN_DEPTH);
    localparam int MIN_LAG = MIN_DEPTH / 2;

    logic [FW-1:0] flen;
    logic [AW-1:0] ring_waddr, ring_wnext, ring_raddr, mem_waddr, mem_raddr;
    logic [MW-1:0] min_wp, min_rp;
    logic          reset_q, align_q, min_q;
    logic          reset_rise, align_rise, min_rise;
    logic          slip_rep, slip_del;

    // Frame length and command edge detection.
    always_comb begin
        flen       = e1_mode ? FW'(E1_FRAME_BITS) : FW'(T1_FRAME_BITS);
        reset_rise = cmd_reset && !reset_q;
        align_rise = cmd_align && !align_q;
        min_rise   = min_delay && !min_q;
    end

    // Remember previous command levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_q <= 1'b0;
            align_q <= 1'b0;
            min_q   <= 1'b0;
        end else begin
            reset_q <= cmd_reset;
            align_q <= cmd_align;
            min_q   <= min_delay;
        end
    end

    es_wr_ctrl #(.AW(AW), .FW(FW)) u_wr (
        .clk(clk), .rst_n(rst_n), .flen(flen),
        .wr_en(wr_en), .wr_sync(wr_sync),
        .waddr(ring_waddr), .wnext(ring_wnext)
    );

    es_rd_ctrl #(.AW(AW), .FW(FW)) u_rd (
        .clk(clk), .rst_n(rst_n), .flen(flen),
        .rd_en(rd_en), .rd_sync(rd_sync), .wnext(ring_wnext),
        .slip_en(!min_delay), .init_reset(reset_rise && !min_delay),
        .init_align(align_rise && !min_delay), .tx_dir(tx_dir),
        .raddr(ring_raddr), .slip_rep(slip_rep), .slip_del(slip_del)
    );

    // Fixed-lag pointers for minimum delay mode, recentred on entry or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_wp <= '0;
            min_rp <= '0;
        end else begin
            if (wr_en) min_wp <= min_wp + MW'(1);
            if (min_rise || (reset_rise && min_delay)) min_rp <= min_wp - MW'(MIN_LAG);
            else if (rd_en)                            min_rp <= min_rp + MW'(1);
        end
    end

    // Select the ring that addresses storage.
    always_comb begin
        mem_waddr = min_delay ? AW'(min_wp) : ring_waddr;
        mem_raddr = min_delay ? AW'(min_rp) : ring_raddr;
    end

    es_bit_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(mem_waddr), .wdata(wr_data),
        .re(rd_en), .raddr(mem_raddr), .rdata(rd_data)
    );

    // Sticky slip flag and last slip direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slip_flag <= 1'b0;
            slip_dir  <= 2'b00;
        end else begin
            slip_flag <= slip_clr ? 1'b0 : (slip_flag || slip_rep || slip_del);
            if (slip_rep || slip_del) begin
                slip_dir[DIR_REPEAT] <= slip_rep;
                slip_dir[DIR_DELETE] <= slip_del;
            end
        end
    end
endmodule

// File: rtl/es_frame_store_chk.sv
// Port-level properties of the frame elastic store.
module es_frame_store_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       rd_data,
    input logic       min_delay,
    input logic       slip_clr,
    input logic       slip_flag,
    input logic [1:0] slip_dir
);
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R3 and R4: a set flag always carries exactly one direction code.
    p_dir_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slip_flag |-> ($countones(slip_dir) == 1));

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_flag && !slip_clr) |=> slip_flag);

    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slip_clr |=> !slip_flag);

    p_min_noslip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        min_delay |=> !$rose(slip_flag));

    p_min_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        min_delay |=> $stable(slip_dir));
endmodule

bind es_frame_store es_frame_store_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .min_delay(min_delay), .slip_clr(slip_clr),
    .slip_flag(slip_flag), .slip_dir(slip_dir)
);

// File: tb/es_frame_store_test.sv
// Directed bench: one task per scenario, each checking its own results.
module es_frame_store_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic e1_mode = 1'b0, min_delay = 1'b0, tx_dir = 1'b1;
    logic wr_en = 1'b0, wr_sync = 1'b0, wr_data = 1'b0;
    logic rd_en = 1'b0, rd_sync = 1'b0;
    logic cmd_reset = 1'b0, cmd_align = 1'b0, slip_clr = 1'b0;
    logic rd_data, slip_flag;
    logic [1:0] slip_dir;

    int n_chk = 0;
    int n_fail = 0;
    int cur_f = 193;
    bit done = 1'b0;

    always #5 clk = ~clk;

    es_frame_store uut (
        .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .min_delay(min_delay),
        .tx_dir(tx_dir), .wr_en(wr_en), .wr_sync(wr_sync), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sync(rd_sync), .rd_data(rd_data),
        .cmd_reset(cmd_reset), .cmd_align(cmd_align), .slip_clr(slip_clr),
        .slip_flag(slip_flag), .slip_dir(slip_dir)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input logic we, input logic wd, input logic ws,
                        input logic re, input logic rs);
        @(negedge clk);
        wr_en = we; wr_data = wd; wr_sync = ws; rd_en = re; rd_sync = rs;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset(input logic e1);
        @(negedge clk);
        rst_n = 1'b0; e1_mode = e1; min_delay = 1'b0;
        cmd_reset = 1'b0; cmd_align = 1'b0; slip_clr = 1'b0;
        cur_f = e1 ? 256 : 193;
        repeat (3) idle();
        @(negedge clk);
        rst_n = 1'b1;
        idle();
    endtask

    task automatic clear_flag();
        @(negedge clk);
        slip_clr = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        slip_clr = 1'b0;
    endtask

    task automatic pulse_reset(input bit hold);
        @(negedge clk);
        cmd_reset = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        #1;
        if (!hold) begin
            @(negedge clk);
            cmd_reset = 1'b0;
        end
    endtask

    task automatic pulse_align();
        @(negedge clk);
        cmd_align = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        cmd_align = 1'b0;
    endtask

    // Clear the ring with zeros, write one mark, count read strobes to it.
    task automatic measure(output int lat);
        for (int i = 0; i < 2 * cur_f; i++) tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        lat = -1;
        for (int j = 1; j <= 2 * cur_f + 2; j++) begin
            tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
            if (lat < 0 && rd_data) lat = j;
        end
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk(slip_flag == 1'b0, "R2 flag after reset", slip_flag, 0);
        chk(slip_dir == 2'b00, "R2 dir after reset", slip_dir, 0);
        chk(rd_data == 1'b0, "R2 data after reset", rd_data, 0);
    endtask

    task automatic t_base_latency(input logic e1);
        int lat;
        do_reset(e1);
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(slip_flag == 1'b1, "R3 startup repeat flag", slip_flag, 1);
        chk(slip_dir == 2'b01, "R3 startup repeat dir", slip_dir, 1);
        clear_flag();
        measure(lat);
        chk(lat == cur_f, "R1 one-frame latency", lat, cur_f);
    endtask

    task automatic t_hold();
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < cur_f; i++) tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(rd_data == 1'b1, "R1 mark after one frame", rd_data, 1);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rd_data == 1'b1, "R2 data held without rd_en", rd_data, 1);
    endtask

    task automatic t_resync();
        int lat;
        do_reset(1'b0);
        for (int i = 0; i < 250; i++) tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        clear_flag();
        measure(lat);
        chk(lat == 250 - cur_f, "R10 mid-frame read sync", lat, 250 - cur_f);
    endtask

    task automatic t_init_windows();
        int lat;
        do_reset(1'b0);
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        clear_flag();
        for (int i = 0; i < 60; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tx_dir = 1'b1;
        pulse_reset(1'b0);
        measure(lat);
        chk(lat >= cur_f && lat < 2 * cur_f, "R6 transmit reset window", lat, cur_f + 60);
        tx_dir = 1'b0;
        pulse_reset(1'b0);
        measure(lat);
        chk(lat >= 0 && lat < cur_f, "R6 receive reset window", lat, 60);
        pulse_align();
        measure(lat);
        chk(2 * lat >= cur_f && 2 * lat < 3 * cur_f, "R8 align window", lat, cur_f + 60);
    endtask

    task automatic t_edge_only();
        int lat;
        tx_dir = 1'b1;
        pulse_reset(1'b1);
        for (int i = 0; i < 100; i++) tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        measure(lat);
        chk(lat == cur_f - 40, "R7 held reset does not recentre", lat, cur_f - 40);
        @(negedge clk);
        cmd_reset = 1'b0;
    endtask

    task automatic t_slip_repeat();
        for (int i = 0; i < 3000 && !slip_flag; i++)
            tick(i % 2 == 0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(slip_flag == 1'b1, "R3 repeat flag", slip_flag, 1);
        chk(slip_dir == 2'b01, "R3 repeat dir", slip_dir, 1);
        for (int i = 0; i < 50; i++) tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(slip_flag == 1'b1, "R5 flag sticky", slip_flag, 1);
        clear_flag();
        chk(slip_flag == 1'b0, "R5 flag cleared", slip_flag, 0);
        chk(slip_dir == 2'b01, "R5 dir kept after clear", slip_dir, 1);
    endtask

    task automatic t_slip_delete();
        for (int i = 0; i < 3000 && !slip_flag; i++)
            tick(1'b1, 1'b0, 1'b0, i % 2 == 0, 1'b0);
        chk(slip_flag == 1'b1, "R4 delete flag", slip_flag, 1);
        chk(slip_dir == 2'b10, "R4 delete dir", slip_dir, 2);
        clear_flag();
    endtask

    task automatic t_min_delay();
        int lat;
        @(negedge clk);
        min_delay = 1'b1;
        idle();
        measure(lat);
        chk(lat == 16, "R9 fixed lag on entry", lat, 16);
        for (int i = 0; i < 300; i++) tick(i % 2 == 0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(slip_flag == 1'b0, "R9 no slip flag", slip_flag, 0);
        chk(slip_dir == 2'b10, "R9 dir unchanged", slip_dir, 2);
        pulse_reset(1'b0);
        measure(lat);
        chk(lat == 16, "R9 fixed lag after reset", lat, 16);
        @(negedge clk);
        min_delay = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_base_latency(1'b1);
        t_base_latency(1'b0);
        t_hold();
        t_resync();
        t_init_windows();
        t_edge_only();
        t_slip_repeat();
        t_slip_delete();
        t_min_delay();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule